// File: doc/BRIEF.md
# Eight-Register Multi-Cycle Processor Core

This block is a compact multi-cycle integer core for control and sequencing duties inside a larger chip. It holds eight 32-bit general registers and a program counter. It reaches one unified, word-addressed memory through a single request port, which carries the address, a write strobe, write data and read data. Every instruction is a 25-bit pattern in the low bits of a 32-bit word. The core reads it, splits out a 3-bit opcode, up to three register selectors and a 16-bit signed offset, and then carries it out over a few clock cycles.

The instruction set is deliberately small: add, bitwise nand, word load, word store, branch when two registers match, no-op and halt. The memory behind the port is synchronous. Read data belongs to the address driven in the previous cycle. An instruction fetch therefore takes two cycles and execution takes one more. A load adds a fourth cycle, in which it writes back the word it read. Once the core halts it stays quiet until reset. The halted output tells the surrounding logic that the program has ended. A separate flag reports whether the stop came from an unassigned opcode.

Top module: `octreg_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the core drives address 0, the write strobe and both status outputs are low, and all registers read zero.
- R2: Instruction fields are opcode in bits 24..22, first register selector in 21..19, second in 18..16, destination in 2..0 and offset in 15..0. Bits 31..25 are ignored. Opcodes are: 0 add, 1 nand, 2 load, 3 store, 4 branch-if-equal, 5 unassigned, 6 halt, 7 no-op.
- R3: Add writes the sum modulo 2^32 of the two selected registers into the destination register.
- R4: Nand writes the bitwise complement of the AND of the two selected registers into the destination register.
- R5: Load places the memory word at (first register + offset) into the second register.
- R6: Store writes the second register to memory at (first register + offset). The write strobe is high for exactly one cycle.
- R7: Branch-if-equal moves the PC to PC + 1 + offset when the two selected registers are equal, and to PC + 1 otherwise.
- R8: The offset is sign-extended from bit 15, so 0xFFFF adds -1.
- R9: Register 0 always reads zero, and writes that target it are discarded.
- R10: Halt raises the halted output permanently. After that, the address holds at the halt instruction and no further writes occur.
- R11: The unassigned opcode 5 halts the core in the same way as halt and also raises the illegal flag. A normal halt leaves that flag low.
- R12: No-op changes nothing except advancing the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW (16) | Word address for fetch, load or store |
| mem_we | output | 1 | Write strobe for a store |
| mem_wdata | output | DW (32) | Store data |
| mem_rdata | input | DW (32) | Read data for the address of the previous cycle |
| halted | output | 1 | High once execution has stopped |
| illegal | output | 1 | High when the stop came from opcode 5 |

## Verification
The core runs three preloaded programs, and every store it makes is checked against a queue of expected address and data pairs.

- The first program is a countdown loop. It exercises both the taken and the not-taken branch, a backward branch (a negative offset), and a normal halt.
- The second program uses operand patterns whose add carries out of bit 31, so a wrap fault shows up as a wrong sum. The same patterns separate nand from add. This program also writes to register 0, places a no-op in the stream, and stores through a base register with an offset of -1, which shows whether sign extension is correct.
- The third program places opcode 5 ahead of a store. It shows whether the illegal path stops before that store and sets the flag, which a normal halt does not.

// File: rtl/octreg_pkg.sv
package octreg_pkg;
   localparam int OP_W     = 3;
   localparam int SEL_W    = 3;
   localparam int OFF_W    = 16;
   localparam int NUM_REGS = 2 ** SEL_W;
   localparam int OP_LSB   = 22;
   localparam int SA_LSB   = 19;
   localparam int SB_LSB   = 16;
   localparam int SD_LSB   = 0;
   localparam int INSN_W   = OP_LSB + OP_W;

   typedef enum logic [OP_W-1:0] {
      OPC_ADD  = 3'd0,
      OPC_NAND = 3'd1,
      OPC_LOAD = 3'd2,
      OPC_STOR = 3'd3,
      OPC_BEQ  = 3'd4,
      OPC_BAD  = 3'd5,
      OPC_HALT = 3'd6,
      OPC_NOP  = 3'd7
   } opcode_e;

   typedef enum logic [2:0] {
      PH_FETCH,
      PH_CAPT,
      PH_EXEC,
      PH_WBACK,
      PH_STOP
   } phase_e;
endpackage

// File: rtl/octreg_decode.sv
module octreg_decode
   import octreg_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [INSN_W-1:0] insn,
   output opcode_e           op,
   output logic [SEL_W-1:0]  sel_a,
   output logic [SEL_W-1:0]  sel_b,
   output logic [SEL_W-1:0]  sel_d,
   output logic [AW-1:0]     offs
);
   assign op    = opcode_e'(insn[OP_LSB +: OP_W]);
   assign sel_a = insn[SA_LSB +: SEL_W];
   assign sel_b = insn[SB_LSB +: SEL_W];
   assign sel_d = insn[SD_LSB +: SEL_W];
   // signed cast widens from the offset sign bit
   assign offs  = AW'($signed(insn[OFF_W-1:0]));
endmodule

// File: rtl/octreg_regfile.sv
module octreg_regfile
   import octreg_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [DW-1:0]    wr_val,
   input  logic [SEL_W-1:0] rd_sel_a,
   input  logic [SEL_W-1:0] rd_sel_b,
   output logic [DW-1:0]    rd_val_a,
   output logic [DW-1:0]    rd_val_b
);
   logic [DW-1:0] bank [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
         assign bank[gi] = '0;
      end else begin : g_store
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_sel == SEL_W'(gi))
               q <= wr_val;
         end
         assign bank[gi] = q;
      end
   end

   assign rd_val_a = bank[rd_sel_a];
   assign rd_val_b = bank[rd_sel_b];
endmodule

// File: rtl/octreg_alu.sv
module octreg_alu
   import octreg_pkg::*;
#(
   parameter int DW = 32
) (
   input  opcode_e       op,
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   output logic [DW-1:0] result,
   output logic          same
);
   always_comb begin
      if (op == OPC_NAND)
         result = ~(lhs & rhs);
      else
         result = lhs + rhs;
   end
   assign same = (lhs == rhs);
endmodule

// File: rtl/octreg_core.sv
module octreg_core
   import octreg_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          halted,
   output logic          illegal
);
   if (AW < OFF_W) begin : g_bad_aw
      $error("octreg_core: AW must be at least the offset width");
   end
   if (DW < AW || DW < INSN_W) begin : g_bad_dw
      $error("octreg_core: DW too narrow for address or instruction");
   end

   phase_e              phase;
   logic [AW-1:0]       pc;
   logic [INSN_W-1:0]   ir;
   logic                bad_q;

   opcode_e             op;
   logic [SEL_W-1:0]    sa, sb, sd;
   logic [AW-1:0]       offs;
   logic [DW-1:0]       va, vb, alu_res;
   logic                eq;
   logic [AW-1:0]       eff_addr, pc_inc, br_dest;
   logic                rf_we;
   logic [SEL_W-1:0]    rf_sel;
   logic [DW-1:0]       rf_val;
   logic                mem_op;

   octreg_decode #(.AW(AW)) i_dec (
      .insn(ir), .op(op), .sel_a(sa), .sel_b(sb), .sel_d(sd), .offs(offs)
   );

   octreg_regfile #(.DW(DW)) i_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rf_we), .wr_sel(rf_sel), .wr_val(rf_val),
      .rd_sel_a(sa), .rd_sel_b(sb), .rd_val_a(va), .rd_val_b(vb)
   );

   octreg_alu #(.DW(DW)) i_alu (
      .op(op), .lhs(va), .rhs(vb), .result(alu_res), .same(eq)
   );

   assign eff_addr = va[AW-1:0] + offs;
   assign pc_inc   = pc + AW'(1);
   assign br_dest  = pc_inc + offs;
   assign mem_op   = (phase == PH_EXEC) && (op == OPC_LOAD || op == OPC_STOR);

   always_comb begin
      rf_we  = 1'b0;
      rf_sel = sd;
      rf_val = alu_res;
      if (phase == PH_EXEC && (op == OPC_ADD || op == OPC_NAND)) begin
         rf_we = 1'b1;
      end else if (phase == PH_WBACK) begin
         rf_we  = 1'b1;
         rf_sel = sb;
         rf_val = mem_rdata;
      end
   end

   assign mem_addr  = mem_op ? eff_addr : pc;
   assign mem_we    = (phase == PH_EXEC) && (op == OPC_STOR);
   assign mem_wdata = vb;
   assign halted    = (phase == PH_STOP);
   assign illegal   = bad_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_FETCH;
         pc    <= '0;
         ir    <= '0;
         bad_q <= 1'b0;
      end else begin
         unique case (phase)
            PH_FETCH: phase <= PH_CAPT;
            PH_CAPT: begin
               ir    <= mem_rdata[INSN_W-1:0];
               phase <= PH_EXEC;
            end
            PH_EXEC: begin
               unique case (op)
                  OPC_LOAD: phase <= PH_WBACK;
                  OPC_BEQ: begin
                     pc    <= eq ? br_dest : pc_inc;
                     phase <= PH_FETCH;
                  end
                  OPC_HALT: phase <= PH_STOP;
                  OPC_BAD: begin
                     bad_q <= 1'b1;
                     phase <= PH_STOP;
                  end
                  default: begin
                     pc    <= pc_inc;
                     phase <= PH_FETCH;
                  end
               endcase
            end
            PH_WBACK: begin
               pc    <= pc_inc;
               phase <= PH_FETCH;
            end
            default: phase <= PH_STOP;
         endcase
      end
   end
endmodule

// File: rtl/octreg_core_chk.sv
module octreg_core_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          halted,
   input logic          illegal
);
   a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (mem_addr == '0 && !mem_we && !halted && !illegal));

   a_r6_store_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(mem_addr)));

   a_r10_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   a_r11_illegal_stops: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted);

   a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> illegal);
endmodule

bind octreg_core octreg_core_chk #(.AW(AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
   .halted(halted), .illegal(illegal)
);

// File: tb/test_octreg_core.sv
`timescale 1ns/1ps
module test_octreg_core;
   localparam int DW = 32;
   localparam int AW = 16;
   localparam int RUN_LIMIT = 5000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic          halted;
   logic          illegal;

   logic          ld_en = 1'b0;
   logic [5:0]    ld_addr = '0;
   logic [31:0]   ld_data = '0;
   logic [31:0]   mem [64];

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      int unsigned addr;
      logic [31:0] data;
      string       req;
   } store_t;
   store_t exp_q[$];

   always #2.5 clk = ~clk;

   octreg_core #(.DW(DW), .AW(AW)) i_octreg_core (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .halted(halted), .illegal(illegal)
   );

   // synchronous memory, read data one cycle after the address
   always @(posedge clk) begin
      if (ld_en)
         mem[ld_addr] <= ld_data;
      else if (mem_we)
         mem[mem_addr[5:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[5:0]];
   end

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // monitor: every store must match the head of the expected queue
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10/R11 unexpected store", {16'h0, mem_addr}, 32'hFFFF_FFFF);
         end else begin
            store_t e;
            e = exp_q.pop_front();
            check(mem_addr == AW'(e.addr), {e.req, " addr"}, {16'h0, mem_addr}, e.addr);
            check(mem_wdata == e.data, {e.req, " data"}, mem_wdata, e.data);
         end
      end
   end

   // R2 layout: opcode 24..22, sel A 21..19, sel B 18..16, low 16 bits offset/dest
   function automatic logic [31:0] enc(input int op, input int a, input int b,
                                       input logic [15:0] low);
      return {7'b0, op[2:0], a[2:0], b[2:0], low};
   endfunction

   task automatic expect_store(input int unsigned a, input logic [31:0] d,
                               input string req);
      store_t e;
      e.addr = a; e.data = d; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a[5:0]; ld_data = d;
   endtask

   task automatic begin_load;
      rst_n = 1'b0;
      exp_q.delete();
      for (int i = 0; i < 64; i++) poke(i, 32'h0);
   endtask

   task automatic run(input string tag);
      int cyc;
      @(negedge clk);
      ld_en = 1'b0;
      check(mem_addr == '0 && !mem_we && !halted && !illegal,
            {"R1 reset outputs ", tag}, {mem_addr, 13'b0, mem_we, halted, illegal}, 32'h0);
      rst_n = 1'b1;
      cyc = 0;
      while (!halted && cyc < RUN_LIMIT) begin
         @(negedge clk);
         cyc++;
      end
      if (!halted) check(1'b0, {"R10 watchdog ", tag}, cyc, RUN_LIMIT);
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, {"R6 pending stores ", tag}, exp_q.size(), 0);
   endtask

   initial begin
      logic [31:0] va, vb;
      repeat (3) @(negedge clk);

      // program 1: countdown loop
      begin_load;
      poke(0, enc(2, 0, 1, 16'd10));        // R5 load r1 = 5
      poke(1, enc(2, 0, 2, 16'd11));        // load r2 = -1
      poke(2, enc(0, 1, 2, 16'd1));         // R3 r1 = r1 + r2
      poke(3, enc(4, 0, 1, 16'd1));         // R7 exit when r1 == 0
      poke(4, enc(4, 0, 0, 16'hFFFD));      // R8 back by three
      poke(5, enc(3, 0, 1, 16'd20));
      poke(6, enc(3, 0, 2, 16'd21));
      poke(7, enc(6, 0, 0, 16'd0));
      poke(10, 32'd5);
      poke(11, 32'hFFFF_FFFF);
      expect_store(20, 32'h0, "R7 loop result");
      expect_store(21, 32'hFFFF_FFFF, "R5 loaded value");
      run("loop");
      check(halted, "R10 halted after halt", halted, 1);
      check(!illegal, "R11 no flag on halt", illegal, 0);
      check(mem_addr == 16'd7, "R10 address held at halt", mem_addr, 7);
      check(mem[20] == 32'h0, "R7 final r1", mem[20], 0);

      // program 2: arithmetic, r0, no-op, negative offset
      va = 32'h1234_5678;
      vb = 32'hF0F0_F0F0;
      begin_load;
      poke(0,  enc(2, 0, 1, 16'd30));
      poke(1,  enc(2, 0, 2, 16'd31));
      poke(2,  enc(0, 1, 2, 16'd3));        // R3 add
      poke(3,  enc(1, 1, 2, 16'd4));        // R4 nand
      poke(4,  enc(0, 1, 1, 16'd0));        // R9 write to r0
      poke(5,  enc(7, 0, 0, 16'd0));        // R12 no-op
      poke(6,  enc(3, 0, 3, 16'd40));
      poke(7,  enc(3, 0, 4, 16'd41));
      poke(8,  enc(3, 0, 0, 16'd42));
      poke(9,  enc(2, 0, 5, 16'd32));
      poke(10, enc(3, 5, 1, 16'hFFFF));     // R8 base 50 minus one
      poke(11, enc(4, 1, 2, 16'd5));        // R7 not taken
      poke(12, enc(3, 0, 2, 16'd43));
      poke(13, enc(6, 0, 0, 16'd0) | 32'hFE00_0000); // R2 high bits ignored
      poke(30, va);
      poke(31, vb);
      poke(32, 32'd50);
      expect_store(40, va + vb, "R3 add wraps");
      expect_store(41, ~(va & vb), "R4 nand");
      expect_store(42, 32'h0, "R9 r0 stays zero");
      expect_store(49, va, "R8 negative offset");
      expect_store(43, vb, "R7/R12 fall through");
      run("alu");
      check(halted && !illegal, "R2 halt with high bits set", {halted, illegal}, 2);
      check(mem_addr == 16'd13, "R12 pc reached halt", mem_addr, 13);

      // program 3: unassigned opcode
      begin_load;
      poke(0, enc(2, 0, 1, 16'd30));
      poke(1, enc(3, 0, 1, 16'd44));
      poke(2, enc(5, 0, 0, 16'd0));
      poke(3, enc(3, 0, 1, 16'd46));
      poke(30, 32'hA5A5_0001);
      poke(46, 32'h77);
      expect_store(44, 32'hA5A5_0001, "R6 store before stop");
      run("illegal");
      check(halted, "R11 stops", halted, 1);
      check(illegal, "R11 flag raised", illegal, 1);
      check(mem_addr == 16'd2, "R11 address held", mem_addr, 2);
      check(mem[46] == 32'h77, "R11 later store suppressed", mem[46], 32'h77);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule